// File: doc/BRIEF.md
# Default Address Window Classifier

This unit sorts a virtual address into one of the fixed windows that exist before any translation tables are set up. It accepts an address, a flag that selects a 32-bit or 64-bit address space, and a 2-bit privilege level, where 0 is the most privileged level and 3 is user level. One clock after a valid request it reports four things: the window class, whether the access needs a table walk, any faults, and, for a direct-mapped window, the physical address with a cache attribute.

Page-mapped windows only raise the walk flag. The translation itself happens elsewhere. Direct-mapped windows get their physical address by clearing fixed high bits of the virtual address. In 64-bit mode the cache attribute comes from two address bits just below the window selector. Faults block everything else: if a fault is raised, the walk flag, the physical address and the attribute are all zero.

Top module: `addrwin_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, `out_valid` is 0 and every other output is 0.
- R2: A request taken with `in_valid`=1 on a clock edge appears on the outputs after that edge, with `out_valid`=1 for that one cycle. After a cycle with `in_valid`=0, `out_valid` is 0 and the data outputs keep their previous values.
- R3: In 32-bit mode (`in_wide`=0), an address with bit 31 = 0 gives class USER (code 0), `out_walk`=1, attribute 1 and physical address 0. This holds at every privilege level.
- R4: In 32-bit mode, an address with bits 31:30 = 10 gives class DIRECT (code 1). The physical address is bits 29:0 of the address, zero-extended. The attribute is 0 (strongly-ordered uncached) when bit 29 = 0, and 1 (coherent cached) when bit 29 = 1.
- R5: In 32-bit mode, an address with bits 31:30 = 11 gives class KERNEL (code 2), `out_walk`=1 and attribute 1.
- R6: A nonzero privilege level on any class other than USER raises `out_fault_priv`. This covers RSVD as well as DIRECT and KERNEL.
- R7: In 64-bit mode (`in_wide`=1), address bits 63:62 select the class. 00 gives USER and 11 gives KERNEL. Both are page-mapped, with `out_walk`=1 and attribute 1.
- R8: In 64-bit mode, bits 63:62 = 10 gives class DIRECT. The physical address is the address with bits 63:60 cleared, and the attribute is bits 61:60 (0 strongly-ordered uncached, 1 coherent cached, 2 weakly-ordered uncached).
- R9: In 64-bit mode, a DIRECT address whose bits 61:60 = 11 raises `out_fault_attr`.
- R10: In 64-bit mode, bits 63:62 = 01 gives class RSVD (code 3) and raises `out_fault_rsvd`.
- R11: In 32-bit mode, address bits 63:32 have no effect on any output.
- R12: When any fault is raised, `out_walk` is 0, `out_paddr` is 0 and `out_attr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_wide | input | 1 | 1 = 64-bit address space, 0 = 32-bit |
| in_priv | input | 2 | Privilege level, 0 highest, 3 user |
| in_vaddr | input | 64 | Virtual address |
| out_valid | output | 1 | Result present this cycle |
| out_paddr | output | 64 | Physical address for a direct window, else 0 |
| out_attr | output | 2 | Cache attribute code |
| out_win | output | 2 | Window class: 0 USER, 1 DIRECT, 2 KERNEL, 3 RSVD |
| out_walk | output | 1 | Page walk required |
| out_fault_priv | output | 1 | Privilege violation |
| out_fault_attr | output | 1 | Undefined cache attribute in a 64-bit direct window |
| out_fault_rsvd | output | 1 | Reserved 64-bit window |

## Verification
The 32-bit addresses are chosen at the edges of each window, such as 0x7FFFFFFF against 0x80000000, and 0xBFFFFFFF against 0xC0000000. These show whether the bit 31:30 split and the bit 29 attribute choice are decoded correctly. The 64-bit addresses go through all four selector values and all four values of bits 61:60, which separates the attribute pass-through from the attribute fault and the reserved window. The same direct addresses are then sent at privilege 0 and at a nonzero privilege, to tell privilege gating apart from decoding. A 32-bit request with garbage in the upper word shows that those bits are ignored, and idle gaps between requests show that the outputs hold their values.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;
    localparam int ADDR_W   = 64;
    localparam int NARROW_W = 32;
    localparam int SEL_W    = 2;

    typedef enum logic [SEL_W-1:0] {
        WIN_USER   = 2'd0,
        WIN_DIRECT = 2'd1,
        WIN_KERNEL = 2'd2,
        WIN_RSVD   = 2'd3
    } win_e;

    localparam logic [1:0] ATTR_SO  = 2'd0;
    localparam logic [1:0] ATTR_CC  = 2'd1;
    localparam logic [1:0] ATTR_BAD = 2'd3;
    localparam logic [1:0] PRIV_TOP = 2'd0;

    typedef struct packed {
        logic [ADDR_W-1:0] paddr;
        logic [1:0]        attr;
        win_e              win;
        logic              walk;
        logic              f_priv;
        logic              f_attr;
        logic              f_rsvd;
    } xlat_t;
endpackage

// File: rtl/addrwin_dec32.sv
module addrwin_dec32
    import addrwin_pkg::*;
(
    input  logic [NARROW_W-1:0] va,
    input  logic [1:0]          priv,
    output xlat_t               res
);
    localparam int KEEP_W = NARROW_W - SEL_W;

    always_comb begin
        res = '0;
        unique case (va[NARROW_W-1 -: SEL_W])
            2'b00, 2'b01: begin
                res.win  = WIN_USER;
                res.walk = 1'b1;
                res.attr = ATTR_CC;
            end
            2'b10: begin
                res.win   = WIN_DIRECT;
                res.paddr = {{(ADDR_W-KEEP_W){1'b0}}, va[KEEP_W-1:0]};
                res.attr  = va[KEEP_W-1] ? ATTR_CC : ATTR_SO;
            end
            default: begin
                res.win  = WIN_KERNEL;
                res.walk = 1'b1;
                res.attr = ATTR_CC;
            end
        endcase
        res.f_priv = (priv != PRIV_TOP) && (res.win != WIN_USER);
    end
endmodule

// File: rtl/addrwin_dec64.sv
module addrwin_dec64
    import addrwin_pkg::*;
(
    input  logic [ADDR_W-1:0] va,
    input  logic [1:0]        priv,
    output xlat_t             res
);
    localparam int CLR_W  = 4;
    localparam int KEEP_W = ADDR_W - CLR_W;

    always_comb begin
        res = '0;
        unique case (va[ADDR_W-1 -: SEL_W])
            2'b00: begin
                res.win  = WIN_USER;
                res.walk = 1'b1;
                res.attr = ATTR_CC;
            end
            2'b11: begin
                res.win  = WIN_KERNEL;
                res.walk = 1'b1;
                res.attr = ATTR_CC;
            end
            2'b10: begin
                res.win    = WIN_DIRECT;
                res.paddr  = {{CLR_W{1'b0}}, va[KEEP_W-1:0]};
                res.attr   = va[KEEP_W+1:KEEP_W];
                res.f_attr = (va[KEEP_W+1:KEEP_W] == ATTR_BAD);
            end
            default: begin
                res.win    = WIN_RSVD;
                res.f_rsvd = 1'b1;
            end
        endcase
        res.f_priv = (priv != PRIV_TOP) && (res.win != WIN_USER);
    end
endmodule

// File: rtl/addrwin_top.sv
module addrwin_top
    import addrwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_wide,
    input  logic [1:0]        in_priv,
    input  logic [ADDR_W-1:0] in_vaddr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_paddr,
    output logic [1:0]        out_attr,
    output logic [1:0]        out_win,
    output logic              out_walk,
    output logic              out_fault_priv,
    output logic              out_fault_attr,
    output logic              out_fault_rsvd
);
    typedef struct packed {
        logic  valid;
        xlat_t x;
    } state_t;

    xlat_t  r32, r64, sel;
    state_t st_d, st_q;

    addrwin_dec32 u_dec32 (
        .va   (in_vaddr[NARROW_W-1:0]),
        .priv (in_priv),
        .res  (r32)
    );

    addrwin_dec64 u_dec64 (
        .va   (in_vaddr),
        .priv (in_priv),
        .res  (r64)
    );

    always_comb begin
        sel = in_wide ? r64 : r32;
        if (sel.f_priv || sel.f_attr || sel.f_rsvd) begin
            sel.paddr = '0;
            sel.attr  = '0;
            sel.walk  = 1'b0;
        end
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.x = sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid      = st_q.valid;
    assign out_paddr      = st_q.x.paddr;
    assign out_attr       = st_q.x.attr;
    assign out_win        = st_q.x.win;
    assign out_walk       = st_q.x.walk;
    assign out_fault_priv = st_q.x.f_priv;
    assign out_fault_attr = st_q.x.f_attr;
    assign out_fault_rsvd = st_q.x.f_rsvd;

    // R2: a result only follows a request
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R2: idle cycles leave the data outputs unchanged
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_paddr) && $stable(out_win) && $stable(out_attr)));

    // R12: a fault suppresses walk, address and attribute
    a_r12_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fault_priv || out_fault_attr || out_fault_rsvd)
            |-> (out_paddr == '0 && !out_walk && out_attr == 2'd0));

    // R6: user level faults exactly when the window is not USER
    a_r6_user_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_priv == 2'd3)
            |=> (out_fault_priv == (out_win != WIN_USER)));

    // R10: the reserved 64-bit window always faults
    a_r10_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_wide && in_vaddr[ADDR_W-1 -: SEL_W] == 2'b01)
            |=> (out_fault_rsvd && out_win == WIN_RSVD));

    // R3: user window never faults on privilege
    a_r3_user_open: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_win == WIN_USER) |-> (!out_fault_priv && out_walk));
endmodule

// File: tb/tb_addrwin_top.sv
module tb_addrwin_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_wide = 1'b0;
    logic [1:0]  in_priv = 2'd0;
    logic [63:0] in_vaddr = '0;
    logic        out_valid;
    logic [63:0] out_paddr;
    logic [1:0]  out_attr;
    logic [1:0]  out_win;
    logic        out_walk;
    logic        out_fault_priv;
    logic        out_fault_attr;
    logic        out_fault_rsvd;

    always #4 clk = ~clk;

    addrwin_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
        .in_priv(in_priv), .in_vaddr(in_vaddr), .out_valid(out_valid),
        .out_paddr(out_paddr), .out_attr(out_attr), .out_win(out_win),
        .out_walk(out_walk), .out_fault_priv(out_fault_priv),
        .out_fault_attr(out_fault_attr), .out_fault_rsvd(out_fault_rsvd)
    );

    typedef struct packed {
        logic [63:0] pa;
        logic [1:0]  at;
        logic [1:0]  wn;
        logic        wk;
        logic        fp;
        logic        fa;
        logic        fr;
    } exp_t;

    exp_t  q[$];
    string tq[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    exp_t  last_exp = '0;

    function automatic exp_t model(input bit w, input logic [1:0] p, input logic [63:0] va);
        exp_t e;
        bit   page;
        e = '0;
        page = 1'b0;
        if (!w) begin
            if (!va[31]) begin e.wn = 2'd0; page = 1'b1; end
            else if (va[30]) begin e.wn = 2'd2; page = 1'b1; end
            else begin
                e.wn = 2'd1;
                e.pa = {34'd0, va[29:0]};
                e.at = va[29] ? 2'd1 : 2'd0;
            end
        end else begin
            case (va[63:62])
                2'b00: begin e.wn = 2'd0; page = 1'b1; end
                2'b11: begin e.wn = 2'd2; page = 1'b1; end
                2'b10: begin
                    e.wn = 2'd1;
                    e.pa = {4'd0, va[59:0]};
                    e.at = va[61:60];
                    e.fa = (va[61:60] == 2'd3);
                end
                default: begin e.wn = 2'd3; e.fr = 1'b1; end
            endcase
        end
        if (page) begin e.wk = 1'b1; e.at = 2'd1; end
        e.fp = (p != 2'd0) && (e.wn != 2'd0);
        if (e.fp || e.fa || e.fr) begin e.pa = '0; e.at = '0; e.wk = 1'b0; end
        return e;
    endfunction

    function automatic exp_t observed();
        exp_t o;
        o.pa = out_paddr; o.at = out_attr; o.wn = out_win; o.wk = out_walk;
        o.fp = out_fault_priv; o.fa = out_fault_attr; o.fr = out_fault_rsvd;
        return o;
    endfunction

    task automatic check(input string tag, input exp_t act, input exp_t exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got pa=%h at=%0d win=%0d walk=%0b fp=%0b fa=%0b fr=%0b, expected pa=%h at=%0d win=%0d walk=%0b fp=%0b fa=%0b fr=%0b",
                     tag, act.pa, act.at, act.wn, act.wk, act.fp, act.fa, act.fr,
                     exp.pa, exp.at, exp.wn, exp.wk, exp.fp, exp.fa, exp.fr);
        end
    endtask

    task automatic drive(input string tag, input bit w, input logic [1:0] p, input logic [63:0] va);
        @(negedge clk);
        in_valid = 1'b1;
        in_wide  = w;
        in_priv  = p;
        in_vaddr = va;
        q.push_back(model(w, p, va));
        tq.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_vaddr = 64'hDEAD_BEEF_DEAD_BEEF;
        end
    endtask

    // monitor: pop and compare every produced result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                n_run++;
                n_fail++;
                $display("FAIL R2: unexpected out_valid, got 1 expected 0");
            end else begin
                exp_t  e;
                string t;
                e = q.pop_front();
                t = tq.pop_front();
                check(t, observed(), e);
                last_exp = e;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", observed(), '0);
        n_run++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: out_valid got %0b expected 0", out_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", observed(), '0);

        // 32-bit windows
        drive("R3 user low p3",        1'b0, 2'd3, 64'h0000_0000_0000_1000);
        drive("R3 user top p0",        1'b0, 2'd0, 64'h0000_0000_7FFF_FFFF);
        drive("R4 uncached direct",    1'b0, 2'd0, 64'h0000_0000_8000_1000);
        drive("R4 cached direct",      1'b0, 2'd0, 64'h0000_0000_A000_1000);
        drive("R4 cached direct top",  1'b0, 2'd0, 64'h0000_0000_BFFF_FFFF);
        drive("R5 kernel page",        1'b0, 2'd0, 64'h0000_0000_C000_0000);
        drive("R6 direct at p3",       1'b0, 2'd3, 64'h0000_0000_8000_1000);
        drive("R6 kernel at p1",       1'b0, 2'd1, 64'h0000_0000_C000_0000);
        drive("R11 upper bits ignored",1'b0, 2'd0, 64'hFFFF_FFFF_8000_1000);
        drive("R11 upper bits user",   1'b0, 2'd2, 64'hC000_0000_0000_0040);
        idle(3);
        // R2: hold after idle
        n_run++;
        if (out_valid !== 1'b0 || observed() !== last_exp) begin
            n_fail++;
            $display("FAIL R2: hold got valid=%0b pa=%h expected valid=0 pa=%h",
                     out_valid, out_paddr, last_exp.pa);
        end

        // 64-bit windows
        drive("R7 user page p3",       1'b1, 2'd3, 64'h0000_0000_0000_1000);
        drive("R7 user page top",      1'b1, 2'd0, 64'h3FFF_FFFF_FFFF_FFFF);
        drive("R8 strongly ordered",   1'b1, 2'd0, 64'h8000_0000_0000_1000);
        drive("R8 coherent cached",    1'b1, 2'd0, 64'h9000_0000_0000_1000);
        drive("R8 weakly ordered",     1'b1, 2'd0, 64'hA000_0000_0000_1000);
        drive("R9 bad attribute",      1'b1, 2'd0, 64'hB000_0000_0000_1000);
        drive("R10 reserved window",   1'b1, 2'd0, 64'h4000_0000_0000_1000);
        idle(1);
        drive("R7 kernel page",        1'b1, 2'd0, 64'hC000_0000_0000_2000);
        drive("R6 kernel at p3",       1'b1, 2'd3, 64'hC000_0000_0000_2000);
        drive("R6 direct at p2",       1'b1, 2'd2, 64'h9000_0000_1234_5678);
        drive("R12 rsvd and priv",     1'b1, 2'd3, 64'h7FFF_0000_0000_0000);
        drive("R12 bad attr and priv", 1'b1, 2'd1, 64'hBFFF_FFFF_FFFF_FFFF);
        idle(4);
        n_run++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: pending results got %0d expected 0", q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule